// File: doc/BRIEF.md
# Reloadable Down-Counter Timer Channel

This block is a single timer channel. A counter of `CNT_W` bits steps down by one on each prescaler tick while the channel runs. Expiry happens on underflow, which is the step taken from zero, and not when the count reaches zero. A count of N therefore expires on tick N+1. On expiry the channel does one of two things. It reloads from its reload register and keeps running, or it stops. It can also raise a sticky pending flag and a one-cycle interrupt pulse.

Software reaches the channel through three write strobes that share one data bus: counter, reload and control. All three registers can be read back at all times. The counter read-back is the live count. The run/stop behaviour comes from a two-state machine. `ST_IDLE` means the counter is frozen. `ST_COUNT` means ticks are taken. The transitions are:
- `ST_IDLE` to `ST_COUNT` on a control write with the run bit set.
- `ST_COUNT` to `ST_IDLE` on a control write with the run bit clear.
- `ST_COUNT` to `ST_IDLE` on an expiry while auto-reload is off.

Control word layout (bit: meaning):
- 0: run. Reads as the FSM state.
- 1: auto-reload.
- 2: load strobe.
- 3: interrupt enable.
- 4: pending. Written as 1 to clear it.
- 5: unsupported. Reads 0.
- 6: unsupported. Reads 0.

Top module: `downcount_timer`

## Requirements
- R1: After reset the counter, the reload register and the control word all read 0, and `irq_pulse` is low.
- R2: A counter write sets the count to `wdata` on the next cycle. It does not change the run bit. If the channel runs, counting continues from the written value.
- R3: While running, each cycle with `tick` high and no counter or control write lowers the count by exactly one, as long as the count is not zero.
- R4: Expiry happens on the tick taken while the count is zero. A count loaded with N expires on tick N+1.
- R5: On expiry with auto-reload (bit 1) set, the counter takes the reload value and the run bit stays 1.
- R6: On expiry with auto-reload clear, the run bit drops to 0 and the counter reads all ones.
- R7: On expiry with interrupt enable (bit 3) set, pending (bit 4) becomes 1 and `irq_pulse` is high for exactly the cycle that follows the expiring tick. With bit 3 clear, neither happens.
- R8: Pending is sticky. A control write with bit 4 = 1 clears it. A control write with bit 4 = 0 leaves it unchanged.
- R9: A control write with the load bit (bit 2) set copies the reload register into the counter. Bits 2, 5 and 6 always read back as 0.
- R10: While the run bit is 0, ticks leave the counter unchanged and cause no expiry.
- R11: A reload write updates the reload read-back only. It neither blocks nor alters that cycle's tick on the counter.
- R12: In a cycle with a counter or control write, the tick is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaler tick, one count step per high cycle |
| cnt_we | input | 1 | Counter write strobe |
| rld_we | input | 1 | Reload write strobe |
| ctl_we | input | 1 | Control write strobe |
| wdata | input | CNT_W | Write data shared by the three strobes |
| cnt_rd | output | CNT_W | Live count |
| rld_rd | output | CNT_W | Reload register |
| ctl_rd | output | 7 | Control word read-back |
| irq_pulse | output | 1 | One-cycle interrupt pulse on expiry |

## Verification
The hardest situation to reach is the underflow boundary: the tick taken at a count of zero. At that tick, reload, stop, pending and the pulse all decide in one edge. The stimulus sweeps every combination of the following:
- start counts 0 to 5;
- auto-reload on and off;
- interrupt enable on and off;
- ticks back to back or with idle gaps between them.

The bench computes the expected count after every tick, and the expiring tick index N+1, arithmetically. In the auto-reload cases it then runs a second full period from the reload value. This catches off-by-one reloads and a pulse that lasts more than one cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int CTL_W   = 7;
    localparam int B_RUN   = 0;
    localparam int B_AUTO  = 1;
    localparam int B_LOAD  = 2;
    localparam int B_IE    = 3;
    localparam int B_PEND  = 4;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_COUNT = 1'b1
    } run_state_e;
endpackage

// File: rtl/tmr_fsm.sv
module tmr_fsm
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_we,
    input  logic run_bit,
    input  logic expire,
    input  logic auto_rld,
    output logic running
);
    run_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ctl_we && run_bit) state_d = ST_COUNT;
            end
            ST_COUNT: begin
                if (ctl_we)                   state_d = run_bit ? ST_COUNT : ST_IDLE;
                else if (expire && !auto_rld) state_d = ST_IDLE;
            end
        endcase
    end

    always_comb begin
        running = (state_q == ST_COUNT);
    end
endmodule

// File: rtl/tmr_ctl_reg.sv
module tmr_ctl_reg
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_we,
    input  logic wr_auto,
    input  logic wr_ie,
    input  logic wr_pend,
    input  logic expire,
    output logic auto_rld,
    output logic irq_en,
    output logic pending,
    output logic irq_pulse
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            auto_rld  <= 1'b0;
            irq_en    <= 1'b0;
            pending   <= 1'b0;
            irq_pulse <= 1'b0;
        end else begin
            irq_pulse <= expire && irq_en;
            if (ctl_we) begin
                auto_rld <= wr_auto;
                irq_en   <= wr_ie;
                if (wr_pend) pending <= 1'b0;
            end else if (expire && irq_en) begin
                pending <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_we,
    input  logic             rld_we,
    input  logic [CNT_W-1:0] wdata,
    input  logic             take_rld,
    input  logic             wrap,
    input  logic             step,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] reload,
    output logic             at_zero
);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] ALL1 = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n)      reload <= '0;
        else if (rld_we) reload <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        count <= '0;
        else if (cnt_we)   count <= wdata;
        else if (take_rld) count <= reload;
        else if (wrap)     count <= ALL1;
        else if (step)     count <= count - ONE;
    end

    always_comb at_zero = (count == '0);
endmodule

// File: rtl/downcount_timer.sv
module downcount_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cnt_we,
    input  logic             rld_we,
    input  logic             ctl_we,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt_rd,
    output logic [CNT_W-1:0] rld_rd,
    output logic [CTL_W-1:0] ctl_rd,
    output logic             irq_pulse
);
    logic running, auto_rld, irq_en, pending, at_zero;
    logic blocked, live_tick, expire, take_rld, wrap, step;

    always_comb begin
        blocked   = cnt_we || ctl_we;
        live_tick = running && tick && !blocked;
        expire    = live_tick && at_zero;
        step      = live_tick && !at_zero;
        wrap      = expire && !auto_rld;
        take_rld  = (ctl_we && wdata[B_LOAD]) || (expire && auto_rld);
    end

    tmr_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_we   (ctl_we),
        .run_bit  (wdata[B_RUN]),
        .expire   (expire),
        .auto_rld (auto_rld),
        .running  (running)
    );

    tmr_ctl_reg u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (ctl_we),
        .wr_auto   (wdata[B_AUTO]),
        .wr_ie     (wdata[B_IE]),
        .wr_pend   (wdata[B_PEND]),
        .expire    (expire),
        .auto_rld  (auto_rld),
        .irq_en    (irq_en),
        .pending   (pending),
        .irq_pulse (irq_pulse)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_we   (cnt_we),
        .rld_we   (rld_we),
        .wdata    (wdata),
        .take_rld (take_rld),
        .wrap     (wrap),
        .step     (step),
        .count    (cnt_rd),
        .reload   (rld_rd),
        .at_zero  (at_zero)
    );

    always_comb begin
        ctl_rd         = '0;
        ctl_rd[B_RUN]  = running;
        ctl_rd[B_AUTO] = auto_rld;
        ctl_rd[B_IE]   = irq_en;
        ctl_rd[B_PEND] = pending;
    end
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             cnt_we,
    input logic             ctl_we,
    input logic             clr_bit,
    input logic [CNT_W-1:0] cnt_rd,
    input logic [CNT_W-1:0] rld_rd,
    input logic             run_q,
    input logic             auto_q,
    input logic             ie_q,
    input logic             pend_q,
    input logic             irq_pulse
);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] ALL1 = {CNT_W{1'b1}};

    logic quiet;
    always_comb quiet = !cnt_we && !ctl_we;

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && tick && quiet && cnt_rd != '0) |=> (cnt_rd == $past(cnt_rd) - ONE));

    p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && auto_q && tick && quiet && cnt_rd == '0) |=> (run_q && cnt_rd == $past(rld_rd)));

    p_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !auto_q && tick && quiet && cnt_rd == '0) |=> (!run_q && cnt_rd == ALL1));

    p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> (pend_q && ie_q && $past(tick)));

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !(ctl_we && clr_bit)) |=> pend_q);

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && clr_bit) |=> !pend_q);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && quiet) |=> $stable(cnt_rd));
endmodule

bind downcount_timer tmr_chk #(.CNT_W(CNT_W)) u_tmr_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .cnt_we    (cnt_we),
    .ctl_we    (ctl_we),
    .clr_bit   (wdata[4]),
    .cnt_rd    (cnt_rd),
    .rld_rd    (rld_rd),
    .run_q     (ctl_rd[0]),
    .auto_q    (ctl_rd[1]),
    .ie_q      (ctl_rd[3]),
    .pend_q    (ctl_rd[4]),
    .irq_pulse (irq_pulse)
);

// File: tb/downcount_timer_test.sv
module downcount_timer_test;
    localparam int W = 32;
    localparam logic [W-1:0] ALL1 = {W{1'b1}};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic cnt_we = 1'b0;
    logic rld_we = 1'b0;
    logic ctl_we = 1'b0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] cnt_rd, rld_rd;
    logic [6:0] ctl_rd;
    logic irq_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    downcount_timer #(.CNT_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_we(cnt_we), .rld_we(rld_we),
        .ctl_we(ctl_we), .wdata(wdata), .cnt_rd(cnt_rd), .rld_rd(rld_rd),
        .ctl_rd(ctl_rd), .irq_pulse(irq_pulse)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic wr(input int sel, input logic [W-1:0] d, input logic tk);
        cnt_we = (sel == 0); rld_we = (sel == 1); ctl_we = (sel == 2);
        wdata = d; tick = tk;
        @(negedge clk);
        cnt_we = 1'b0; rld_we = 1'b0; ctl_we = 1'b0; tick = 1'b0;
    endtask

    task automatic one_tick();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_case(input int n, input int rv, input bit auto, input bit ie, input int gap);
        logic [W-1:0] ctl;
        ctl = 32'h11 | (W'(auto) << 1) | (W'(ie) << 3);
        wr(1, W'(rv), 1'b0);
        wr(0, W'(n), 1'b0);
        wr(2, ctl, 1'b0);
        for (int k = 1; k <= n; k++) begin
            one_tick();
            chk("R3 count after tick", cnt_rd, W'(n - k));
            chk("R4 no early expiry", W'(irq_pulse), '0);
            idle(gap);
        end
        one_tick();
        chk("R7 pulse on tick N+1", W'(irq_pulse), W'(ie));
        chk("R7 pending on expiry", W'(ctl_rd[4]), W'(ie));
        chk("R5 R6 run bit after expiry", W'(ctl_rd[0]), W'(auto));
        chk("R5 R6 count after expiry", cnt_rd, auto ? W'(rv) : ALL1);
        idle(1);
        chk("R7 pulse lasts one cycle", W'(irq_pulse), '0);
        if (auto) begin
            for (int k = 1; k <= rv; k++) begin
                one_tick();
                idle(gap);
            end
            chk("R5 second period reaches zero", cnt_rd, '0);
            one_tick();
            chk("R5 second expiry pulse", W'(irq_pulse), W'(ie));
            chk("R5 reload again", cnt_rd, W'(rv));
        end
        wr(2, 32'h10, 1'b0);
        chk("R8 write-one clears pending", W'(ctl_rd), '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 counter in reset", cnt_rd, '0);
        chk("R1 reload in reset", rld_rd, '0);
        chk("R1 control in reset", W'(ctl_rd), '0);
        chk("R1 irq in reset", W'(irq_pulse), '0);
        rst_n = 1'b1;
        idle(1);
        chk("R1 counter after reset", cnt_rd, '0);

        for (int g = 0; g < 2; g++)
            for (int a = 0; a < 2; a++)
                for (int e = 0; e < 2; e++)
                    for (int n = 0; n < 6; n++)
                        run_case(n, 2 + n % 3, a[0], e[0], g);

        // R10: stopped channel ignores ticks
        wr(0, 32'd5, 1'b0);
        chk("R2 counter write while stopped", cnt_rd, 32'd5);
        chk("R2 write does not start", W'(ctl_rd[0]), '0);
        repeat (3) one_tick();
        chk("R10 count holds when stopped", cnt_rd, 32'd5);
        wr(0, 32'd9, 1'b0);
        wr(2, 32'h09, 1'b0);
        one_tick(); one_tick();
        chk("R3 running count", cnt_rd, 32'd7);
        wr(2, 32'h08, 1'b0);
        repeat (10) one_tick();
        chk("R10 disabled mid count holds", cnt_rd, 32'd7);
        chk("R10 no expiry while stopped", W'(irq_pulse), '0);

        // R8: sticky pending
        wr(0, 32'd0, 1'b0);
        wr(2, 32'h09, 1'b0);
        one_tick();
        chk("R7 pending set", W'(ctl_rd[4]), 32'd1);
        wr(2, 32'h08, 1'b0);
        chk("R8 write-zero keeps pending", W'(ctl_rd), 32'h18);
        idle(3);
        chk("R8 pending stays", W'(ctl_rd[4]), 32'd1);
        wr(2, 32'h10, 1'b0);
        chk("R8 pending cleared", W'(ctl_rd), 32'h00);

        // R9: load bit
        wr(1, 32'h1234, 1'b0);
        wr(0, 32'd7, 1'b0);
        wr(2, 32'h04, 1'b0);
        chk("R9 load copies reload", cnt_rd, 32'h1234);
        chk("R9 load reads zero", W'(ctl_rd), 32'h00);
        wr(2, 32'h7F, 1'b0);
        chk("R9 bits 2 5 6 read zero", W'(ctl_rd), 32'h0B);
        one_tick();
        chk("R9 counts from loaded value", cnt_rd, 32'h1233);

        // R12: writes take precedence over tick
        wr(0, 32'h40, 1'b1);
        chk("R12 counter write ignores tick", cnt_rd, 32'h40);
        chk("R2 running after counter write", W'(ctl_rd[0]), 32'd1);
        wr(2, 32'h01, 1'b1);
        chk("R12 control write ignores tick", cnt_rd, 32'h40);
        one_tick();
        chk("R2 counts from written value", cnt_rd, 32'h3F);

        // R11: reload write does not block the tick
        wr(1, 32'h99, 1'b1);
        chk("R11 reload read-back", rld_rd, 32'h99);
        chk("R11 tick still applied", cnt_rd, 32'h3E);

        wr(0, ALL1, 1'b0);
        one_tick();
        chk("R3 top value steps", cnt_rd, ALL1 - 32'd1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule